// File: doc/BRIEF.md
# Bus burst sequence splitter

The splitter accepts one transfer request (a start byte address, a word count and a 3-bit policy code) and turns it into an ordered series of bus burst descriptors. Each descriptor carries a burst kind, a beat count and the byte address of its first beat. Descriptors leave on a valid/ready stream, one for each handshake. The block does not drive a bus, move data or apply any address-boundary rule. A downstream bus master takes those tasks from the descriptors.

The policy code sets the burst mix. The low two bits give the largest fixed-length burst allowed (none, 4, 8 or 16 beats). The top bit chooses how the leftover words finish: as single beats, or as one incrementing burst of unspecified length. At every step the splitter issues the largest permitted fixed burst that still fits in the words that remain. Burst sizes therefore only shrink as the sequence goes on. The request port is ready only while no sequence is in progress.

Top module: `burst_seq_splitter`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1 and `desc_valid` is 0.
- R2: Policy codes 0 and 4 emit exactly one descriptor of kind 1 (unspecified-length incrementing) whose beat count equals the whole request length.
- R3: For policy codes 1, 2, 3, 5, 6 and 7, the largest allowed fixed burst is 4, 8 or 16 beats when the low two policy bits are 1, 2 or 3. Each step emits the largest allowed fixed burst that does not exceed the remaining words. Its kind code is 2 for 4 beats, 3 for 8 beats and 4 for 16 beats.
- R4: For policy codes 1 to 3, words left over after the fixed bursts go out one at a time as kind 0 (single) with a beat count of 1.
- R5: For policy codes 5 to 7, a non-zero leftover after the fixed bursts goes out as a single kind 1 descriptor carrying the whole leftover. With no leftover, no such descriptor is emitted.
- R6: The first descriptor's address equals the request address. Each later descriptor's address is the previous address plus 4 bytes times the previous beat count.
- R7: `req_ready` drops when a non-zero-length request is accepted. It stays low until the handshake of the last descriptor and is high on the cycle after that handshake.
- R8: A zero-length request is accepted, produces no descriptor, and leaves `req_ready` high.
- R9: While `desc_valid` is 1 and `desc_ready` is 0, the descriptor kind, beat count and address hold steady.
- R10: Every descriptor has a non-zero beat count no larger than the words still outstanding, and the beat counts of one sequence add up to the request length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the first word |
| req_len | input | LEN_W | Number of words to transfer |
| req_policy | input | 3 | Burst policy code |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_kind | output | 3 | 0 single, 1 unspecified-length incrementing, 2/3/4 fixed 4/8/16 beats |
| desc_beats | output | LEN_W | Beat count of this burst |
| desc_addr | output | ADDR_W | Byte address of the first beat |

## Verification
The in-design properties check, on every cycle, that a stalled descriptor holds steady, that addresses advance by four bytes per beat between descriptors, that beat counts fit the words still outstanding, and that the request port reopens right after the final handshake or a zero-length request. Whether the chosen burst mix matches the policy code is shown only by the bench. That covers the cascade order, single-beat versus incrementing tails, the reserved code, and the number and kinds of descriptors per request. The bench shows it by comparing whole sequences for many lengths and policies against its own model.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

  typedef enum logic [2:0] {
    BK_SINGLE = 3'd0,
    BK_INCR   = 3'd1,
    BK_FIX4   = 3'd2,
    BK_FIX8   = 3'd3,
    BK_FIX16  = 3'd4
  } burst_kind_e;

  localparam int unsigned POLICY_W  = 3;
  localparam int unsigned FIX_LVLS  = 3;
  localparam int unsigned FIX_MIN   = 4;

endpackage

// File: rtl/split_burst_pick.sv
module split_burst_pick
  import burst_split_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [POLICY_W-1:0] policy,
  input  logic [LEN_W-1:0]    remaining,
  output burst_kind_e         kind,
  output logic [LEN_W-1:0]    beats
);

  logic [1:0]          max_lvl;
  logic                tail_incr;
  logic [FIX_LVLS-1:0] fits;

  assign max_lvl   = policy[1:0];
  assign tail_incr = policy[2] | (policy[1:0] == 2'd0);

  genvar g;
  generate
    for (g = 0; g < FIX_LVLS; g++) begin : g_fit
      localparam logic [LEN_W-1:0] LVL_BEATS = LEN_W'(FIX_MIN << g);
      assign fits[g] = (32'(max_lvl) > g) && (remaining >= LVL_BEATS);
    end
  endgenerate

  always_comb begin
    if (tail_incr) begin
      kind  = BK_INCR;
      beats = remaining;
    end else begin
      kind  = BK_SINGLE;
      beats = LEN_W'(1);
    end
    for (int k = 0; k < FIX_LVLS; k++) begin
      if (fits[k]) begin
        kind  = burst_kind_e'(3'(32'(BK_FIX4) + k));
        beats = LEN_W'(FIX_MIN << k);
      end
    end
  end

endmodule

// File: rtl/split_seq_state.sv
module split_seq_state
  import burst_split_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [POLICY_W-1:0] req_policy,
  input  logic                step_ready,
  input  logic [LEN_W-1:0]    step_beats,
  output logic                busy,
  output logic [LEN_W-1:0]    rem,
  output logic [ADDR_W-1:0]   addr,
  output logic [POLICY_W-1:0] policy
);

  logic                busy_q, busy_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [POLICY_W-1:0] pol_q, pol_d;
  logic                load_en;

  assign load_en = (!busy_q && req_valid) || (busy_q && step_ready);

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    pol_d  = pol_q;
    if (!busy_q) begin
      rem_d  = req_len;
      addr_d = req_addr;
      pol_d  = req_policy;
      busy_d = (req_len != '0);
    end else begin
      rem_d  = rem_q - step_beats;
      addr_d = addr_q + (ADDR_W'(step_beats) << BEAT_SHIFT);
      busy_d = (rem_q != step_beats);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      pol_q  <= '0;
    end else if (load_en) begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      addr_q <= addr_d;
      pol_q  <= pol_d;
    end
  end

  assign busy   = busy_q;
  assign rem    = rem_q;
  assign addr   = addr_q;
  assign policy = pol_q;

  // R8: zero-length request leaves the block idle
  assert_zero_len_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid && req_len == '0) |=> !busy_q);

  // R7: a non-zero request makes the block busy
  assert_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid && req_len != '0) |=> busy_q && rem_q == $past(req_len));

endmodule

// File: rtl/burst_seq_splitter.sv
module burst_seq_splitter
  import burst_split_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [2:0]          req_policy,
  output logic                desc_valid,
  input  logic                desc_ready,
  output logic [2:0]          desc_kind,
  output logic [LEN_W-1:0]    desc_beats,
  output logic [ADDR_W-1:0]   desc_addr
);

  localparam int unsigned BEAT_SHIFT = $clog2(BEAT_BYTES);

  logic                busy;
  logic [LEN_W-1:0]    rem;
  logic [ADDR_W-1:0]   cur_addr;
  logic [POLICY_W-1:0] cur_pol;
  burst_kind_e         pick_kind;
  logic [LEN_W-1:0]    pick_beats;
  logic [ADDR_W-1:0]   step_bytes;

  split_burst_pick #(.LEN_W(LEN_W)) u_pick (
    .policy    (cur_pol),
    .remaining (rem),
    .kind      (pick_kind),
    .beats     (pick_beats)
  );

  split_seq_state #(
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W),
    .BEAT_SHIFT (BEAT_SHIFT)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_policy (req_policy),
    .step_ready (desc_ready),
    .step_beats (pick_beats),
    .busy       (busy),
    .rem        (rem),
    .addr       (cur_addr),
    .policy     (cur_pol)
  );

  assign req_ready  = !busy;
  assign desc_valid = busy;
  assign desc_kind  = pick_kind;
  assign desc_beats = pick_beats;
  assign desc_addr  = cur_addr;
  assign step_bytes = ADDR_W'(desc_beats) << BEAT_SHIFT;

  // R9: stalled descriptor holds steady
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=>
      desc_valid && $stable(desc_kind) && $stable(desc_beats) && $stable(desc_addr));

  // R6: address advances by bytes of the previous burst
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=>
      (!desc_valid || desc_addr == $past(desc_addr) + $past(step_bytes)));

  // R10: beat count fits outstanding words
  assert_beats_fit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_beats != '0) && (desc_beats <= rem));

  // R7: request port reopens right after the last handshake
  assert_drain_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && desc_beats == rem) |=> req_ready && !desc_valid);

  // R3: fixed bursts never grow within one sequence
  assert_shrinking_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && desc_kind >= 3'(BK_FIX4)) |=>
      (!desc_valid || desc_beats <= $past(desc_beats)));

endmodule

// File: tb/burst_seq_splitter_tb.sv
`timescale 1ns/1ps
module burst_seq_splitter_tb;

  localparam int LEN_W  = 16;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [2:0]  pol;
    logic [15:0] len;
    logic [31:0] addr;
    logic [7:0]  cnt;
    logic [2:0]  first_k;
    logic [2:0]  last_k;
    logic [15:0] last_b;
  } vec_t;

  // kind codes: 0 single, 1 incr, 2 fix4, 3 fix8, 4 fix16
  localparam vec_t VECS [12] = '{
    '{3'd0, 16'd37, 32'h0000_1000, 8'd1, 3'd1, 3'd1, 16'd37},
    '{3'd1, 16'd10, 32'h0000_2000, 8'd4, 3'd2, 3'd0, 16'd1},
    '{3'd2, 16'd13, 32'h0000_3000, 8'd3, 3'd3, 3'd0, 16'd1},
    '{3'd3, 16'd31, 32'h0000_4000, 8'd6, 3'd4, 3'd0, 16'd1},
    '{3'd5, 16'd10, 32'h0000_5000, 8'd3, 3'd2, 3'd1, 16'd2},
    '{3'd6, 16'd12, 32'h0000_6000, 8'd2, 3'd3, 3'd2, 16'd4},
    '{3'd7, 16'd45, 32'h0000_7000, 8'd5, 3'd4, 3'd1, 16'd1},
    '{3'd4, 16'd9,  32'h0000_8000, 8'd1, 3'd1, 3'd1, 16'd9},
    '{3'd3, 16'd3,  32'h0000_9000, 8'd3, 3'd0, 3'd0, 16'd1},
    '{3'd7, 16'd2,  32'h0000_A000, 8'd1, 3'd1, 3'd1, 16'd2},
    '{3'd1, 16'd4,  32'h0000_B000, 8'd1, 3'd2, 3'd2, 16'd4},
    '{3'd0, 16'd1,  32'hFFFF_FFF0, 8'd1, 3'd1, 3'd1, 16'd1}
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [2:0]        req_policy;
  logic              desc_valid;
  logic              desc_ready;
  logic [2:0]        desc_kind;
  logic [LEN_W-1:0]  desc_beats;
  logic [ADDR_W-1:0] desc_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  burst_seq_splitter #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .BEAT_BYTES(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_policy(req_policy),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_kind(desc_kind), .desc_beats(desc_beats), .desc_addr(desc_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference choice from the requirements
  task automatic model_pick(input logic [2:0] pol, input int rem,
                            output int kind, output int beats);
    int maxf;
    bit incr_tail;
    case (pol)
      3'd1, 3'd5: maxf = 4;
      3'd2, 3'd6: maxf = 8;
      3'd3, 3'd7: maxf = 16;
      default:    maxf = 0;
    endcase
    incr_tail = (maxf == 0) || (pol >= 3'd5);
    if (maxf >= 16 && rem >= 16)     begin kind = 4; beats = 16; end
    else if (maxf >= 8 && rem >= 8)  begin kind = 3; beats = 8;  end
    else if (maxf >= 4 && rem >= 4)  begin kind = 2; beats = 4;  end
    else if (incr_tail)              begin kind = 1; beats = rem; end
    else                             begin kind = 0; beats = 1;  end
  endtask

  function automatic string tag_for(input logic [2:0] pol, input int kind);
    if (kind >= 2)                 return "R3";
    if (kind == 0)                 return "R4";
    if (pol == 3'd0 || pol == 3'd4) return "R2";
    return "R5";
  endfunction

  task automatic send(input logic [2:0] pol, input logic [15:0] len,
                      input logic [31:0] addr);
    @(negedge clk);
    req_valid  = 1'b1;
    req_policy = pol;
    req_len    = len;
    req_addr   = addr;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  // Called at a negedge after send; desc_ready is 1
  task automatic collect(input logic [2:0] pol, input int len, input logic [31:0] addr,
                         output int cnt, output int first_k, output int last_k,
                         output int last_b);
    int rem = len;
    logic [31:0] exp_addr = addr;
    int sum = 0;
    int ek, eb;
    cnt = 0; first_k = -1; last_k = -1; last_b = -1;
    for (int guard = 0; guard < 200; guard++) begin
      if (desc_valid) begin
        model_pick(pol, rem, ek, eb);
        chk(desc_kind == 3'(ek), tag_for(pol, ek), "kind", desc_kind, ek);
        chk(desc_beats == 16'(eb), tag_for(pol, ek), "beats", desc_beats, eb);
        chk(desc_addr == exp_addr, "R6", "addr", desc_addr, exp_addr);
        chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        if (cnt == 0) first_k = desc_kind;
        last_k = desc_kind;
        last_b = desc_beats;
        cnt++;
        sum      += int'(desc_beats);
        rem      -= eb;
        exp_addr += 32'(eb * 4);
      end else if (req_ready) begin
        break;
      end
      @(negedge clk);
    end
    chk(sum == len, "R10", "beat sum", sum, len);
    chk(req_ready == 1'b1, "R7", "ready after drain", req_ready, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, fk, lk, lb;
    logic [2:0]  h_kind;
    logic [15:0] h_beats;
    logic [31:0] h_addr;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_len    = '0;
    req_policy = '0;
    desc_ready = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(desc_valid == 1'b0, "R1", "desc_valid in reset", desc_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(desc_valid == 1'b0, "R1", "desc_valid after reset", desc_valid, 0);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      send(VECS[i].pol, VECS[i].len, VECS[i].addr);
      collect(VECS[i].pol, int'(VECS[i].len), VECS[i].addr, cnt, fk, lk, lb);
      chk(cnt == int'(VECS[i].cnt), "R3", "descriptor count", cnt, VECS[i].cnt);
      chk(fk == int'(VECS[i].first_k), "R3", "first kind", fk, VECS[i].first_k);
      chk(lk == int'(VECS[i].last_k), (VECS[i].pol >= 5) ? "R5" : "R4",
          "last kind", lk, VECS[i].last_k);
      chk(lb == int'(VECS[i].last_b), "R10", "last beats", lb, VECS[i].last_b);
    end

    // R8: zero-length request
    send(3'd3, 16'd0, 32'h0000_C000);
    for (int k = 0; k < 4; k++) begin
      chk(desc_valid == 1'b0, "R8", "no descriptor", desc_valid, 0);
      chk(req_ready == 1'b1, "R8", "ready stays high", req_ready, 1);
      @(negedge clk);
    end

    // R9: backpressure holds the descriptor
    desc_ready = 1'b0;
    send(3'd3, 16'd20, 32'h0000_D000);
    h_kind = desc_kind; h_beats = desc_beats; h_addr = desc_addr;
    chk(h_kind == 3'd4 && h_beats == 16'd16, "R9", "first stalled burst",
        {h_kind, h_beats}, {3'd4, 16'd16});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(desc_valid == 1'b1, "R9", "valid held", desc_valid, 1);
      chk(desc_kind == h_kind && desc_beats == h_beats, "R9", "kind/beats held",
          {desc_kind, desc_beats}, {h_kind, h_beats});
      chk(desc_addr == h_addr, "R9", "addr held", desc_addr, h_addr);
      chk(req_ready == 1'b0, "R7", "ready low while stalled", req_ready, 0);
    end
    desc_ready = 1'b1;
    collect(3'd3, 20, 32'h0000_D000, cnt, fk, lk, lb);
    chk(cnt == 2, "R3", "count after stall", cnt, 2);
    chk(lk == 2, "R3", "tail fix4 after stall", lk, 2);

    // R7: a request offered while busy is not taken
    send(3'd1, 16'd8, 32'h0000_E000);
    req_valid = 1'b1; req_len = 16'd5; req_policy = 3'd0; req_addr = 32'h0000_F000;
    collect(3'd1, 8, 32'h0000_E000, cnt, fk, lk, lb);
    chk(cnt == 2, "R7", "busy request not merged", cnt, 2);
    @(negedge clk);
    req_valid = 1'b0;
    collect(3'd0, 5, 32'h0000_F000, cnt, fk, lk, lb);
    chk(cnt == 1 && lb == 5, "R7", "queued request after drain", lb, 5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule